// File: doc/BRIEF.md
# Write-Protected Configuration Register Bank

This block holds eight 32-bit configuration registers behind a single-cycle memory-mapped strobe interface. Most of the bank is guarded: a write to a guarded register lands only while the bank is open. The bank opens when the key value is written into the low half of the gate register. It closes again when anything else is written there. The gate register and the split-line register are never guarded. Every register can be read at any time.

A write to a guarded register while the bank is closed is dropped silently, with no error response. Field bits that carry no function are cleared on every write, so they always read back as zero. After reset every register holds zero, which means the bank starts closed.

Top module: `cfg_bank`

## Requirements
- R1: After synchronous reset every register reads 32'h0, `rdata` is 32'h0 and the bank is closed.
- R2: Registers sit at byte offsets from `BASE_ADDR` (default 16'h8300) in this order: 0x00 gate, 0x04 general, 0x08 timing, 0x0C output, 0x10 frame start offset, 0x14 line pitch, 0x18 horizontal timing, 0x1C split line. A read strobe loads `rdata` at the clock edge where it is sampled, and `rdata` holds that value until the next read strobe.
- R3: A write to the gate register whose bits 15:0 equal 16'h4758 opens the bank. Bits 31:16 play no part in the key comparison.
- R4: A write to the gate register with any other value in bits 15:0 closes the bank.
- R5: While the bank is closed, writes to general, timing, output, frame start offset, line pitch and horizontal timing leave those registers unchanged.
- R6: While the bank is open, writes to the guarded registers take effect. This includes a write in the bus cycle directly after the opening write.
- R7: The gate and split-line registers accept writes whether the bank is open or closed.
- R8: Writes keep only these bits and clear all others: gate 0x0000FFFF, general 0xFF05FFFF, timing 0x00000FFF, output 0x0000000F, frame start offset 0x003FFFFF, line pitch 0x000003FF, horizontal timing 0x07FF07FF, split line 0x000007FF.
- R9: Guarded registers return their stored contents on a read whether the bank is open or closed.
- R10: An address that is not word-aligned, lies below `BASE_ADDR`, or lies past offset 0x1C matches nothing. A write there changes nothing, and a read there returns 32'h0.
- R11: The open/closed state changes only on a write to the gate register. Writing the key value to any other register does not open the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 16 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |

## Verification
The hardest case to reach is a guarded write in the cycle right after the opening write. It only shows whether the open state takes effect without extra delay. The bench issues the key write and the guarded write on back-to-back clock edges, then reads the guarded register back. A second hard case is a key value written to some register other than the gate, or to an unaligned address in the gate's word. The stimulus places such writes between a closing write and a guarded write, so any accidental opening would show up in the next read-back.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_REGS  = 8;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int KEY_W     = 16;
    localparam logic [KEY_W-1:0] OPEN_KEY = 16'h4758;

    typedef enum logic [IDX_W-1:0] {
        REG_GATE       = 3'd0,
        REG_GENERAL    = 3'd1,
        REG_TIMING     = 3'd2,
        REG_OUTPUT     = 3'd3,
        REG_FB_OFFSET  = 3'd4,
        REG_LINE_PITCH = 3'd5,
        REG_HTIMING    = 3'd6,
        REG_SPLIT_LINE = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        logic     hit;
        reg_idx_e idx;
    } bus_req_t;

    // Bits that hold state; everything else is cleared on write.
    function automatic logic [DATA_W-1:0] live_bits(reg_idx_e r);
        case (r)
            REG_GATE:       return 32'h0000_FFFF;
            REG_GENERAL:    return 32'hFF05_FFFF;
            REG_TIMING:     return 32'h0000_0FFF;
            REG_OUTPUT:     return 32'h0000_000F;
            REG_FB_OFFSET:  return 32'h003F_FFFF;
            REG_LINE_PITCH: return 32'h0000_03FF;
            REG_HTIMING:    return 32'h07FF_07FF;
            REG_SPLIT_LINE: return 32'h0000_07FF;
            default:        return '0;
        endcase
    endfunction

    function automatic logic is_guarded(reg_idx_e r);
        return !(r == REG_GATE || r == REG_SPLIT_LINE);
    endfunction

endpackage

// File: rtl/cfg_bank_decode.sv
module cfg_bank_decode
    import cfg_bank_pkg::*;
#(
    parameter int             ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8300
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output bus_req_t          req
);
    localparam int WORD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] offset;
    logic [WORD_W-1:0] word;
    logic              in_range;

    always_comb begin
        offset   = addr - BASE_ADDR;
        word     = offset[ADDR_W-1:2];
        in_range = (addr >= BASE_ADDR) && (offset[1:0] == 2'b00)
                   && (word < WORD_W'(NUM_REGS));
        req.wr   = wr_en;
        req.rd   = rd_en;
        req.hit  = in_range;
        req.idx  = reg_idx_e'(word[IDX_W-1:0]);
    end
endmodule

// File: rtl/cfg_bank_lock.sv
module cfg_bank_lock
    import cfg_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [KEY_W-1:0] key_in,
    output logic             unlocked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (req.wr && req.hit && req.idx == REG_GATE) begin
            unlocked <= (key_in == OPEN_KEY);
        end
    end
endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs
    import cfg_bank_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  bus_req_t                         req,
    input  logic [DATA_W-1:0]                wdata,
    input  logic                             unlocked,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    output logic [DATA_W-1:0]                rdata
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [IDX_W-1:0] IDXV = IDX_W'(i);
        localparam reg_idx_e          RID  = reg_idx_e'(IDXV);
        localparam logic [DATA_W-1:0] KEEP = live_bits(RID);
        localparam logic              GRD  = is_guarded(RID);

        logic we;
        assign we = req.wr && req.hit && (req.idx == RID) && (!GRD || unlocked);

        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (we)
                regs_q[i] <= wdata & KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (req.rd)
            rdata <= req.hit ? regs_q[req.idx] : '0;
    end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    bus_req_t                        req;
    logic                            unlocked;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    cfg_bank_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .req   (req)
    );

    cfg_bank_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .key_in   (wdata[KEY_W-1:0]),
        .unlocked (unlocked)
    );

    cfg_bank_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wdata    (wdata),
        .unlocked (unlocked),
        .regs_q   (regs_q),
        .rdata    (rdata)
    );
endmodule

// File: rtl/cfg_bank_checker.sv
module cfg_bank_checker
    import cfg_bank_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8300
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [31:0]                     wdata,
    input logic [31:0]                     rdata,
    input logic                            unlocked,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
    localparam logic [ADDR_W-1:0] GATE_A  = BASE_ADDR;
    localparam logic [ADDR_W-1:0] GEN_A   = BASE_ADDR + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] SPLIT_A = BASE_ADDR + ADDR_W'(28);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!unlocked && rdata == 32'h0 && regs_q == '0));

    // R2
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R3
    a_r3_key_opens: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == GATE_A && wdata[15:0] == OPEN_KEY) |=> unlocked);

    // R4
    a_r4_other_closes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == GATE_A && wdata[15:0] != OPEN_KEY) |=> !unlocked);

    // R5
    a_r5_locked_general_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == GEN_A && !unlocked) |=> $stable(regs_q[1]));

    // R7
    a_r7_split_always: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SPLIT_A) |=> (regs_q[7] == ($past(wdata) & 32'h0000_07FF)));

    // R8
    a_r8_general_reserved: assert property (@(posedge clk) disable iff (rst)
        (regs_q[1] & ~32'hFF05_FFFF) == 32'h0);

    // R10
    a_r10_unaligned_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[1:0] != 2'b00) |=> rdata == 32'h0);

    // R11
    a_r11_lock_only_gate: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == GATE_A) |=> $stable(unlocked));
endmodule

bind cfg_bank cfg_bank_checker #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .unlocked (unlocked),
    .regs_q   (regs_q)
);

// File: tb/cfg_bank_test.sv
`timescale 1ns/1ps
module cfg_bank_test;
    localparam logic [15:0] BASE = 16'h8300;
    localparam logic [15:0] A_GATE  = BASE + 16'h00;
    localparam logic [15:0] A_GEN   = BASE + 16'h04;
    localparam logic [15:0] A_TIM   = BASE + 16'h08;
    localparam logic [15:0] A_OUT   = BASE + 16'h0C;
    localparam logic [15:0] A_FB    = BASE + 16'h10;
    localparam logic [15:0] A_PITCH = BASE + 16'h14;
    localparam logic [15:0] A_HTIM  = BASE + 16'h18;
    localparam logic [15:0] A_SPLIT = BASE + 16'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cfg_bank uut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic expect_reg(input string req, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        check("R1 rdata after reset", rdata, 32'h0);
        for (int i = 0; i < 8; i++)
            expect_reg("R1 register after reset", BASE + 16'(4 * i), 32'h0);
    endtask

    task automatic t_locked_start;
        bus_write(A_GEN, 32'hFFFF_FFFF);
        expect_reg("R5 general write while closed", A_GEN, 32'h0);
        bus_write(A_HTIM, 32'h1234_5678);
        expect_reg("R5 htiming write while closed", A_HTIM, 32'h0);
    endtask

    task automatic t_open_back_to_back;
        // key write then guarded write on consecutive edges
        @(negedge clk);
        wr_en = 1'b1; addr = A_GATE; wdata = 32'hABCD_4758;
        @(negedge clk);
        addr = A_GEN; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        expect_reg("R6 guarded write right after opening", A_GEN, 32'hFF05_FFFF);
        expect_reg("R3 gate upper bits ignored, R8 gate mask", A_GATE, 32'h0000_4758);
        bus_write(A_TIM, 32'hFFFF_FFFF);
        expect_reg("R8 timing mask", A_TIM, 32'h0000_0FFF);
        bus_write(A_OUT, 32'hFFFF_FFFA);
        expect_reg("R8 output mask", A_OUT, 32'h0000_000A);
        bus_write(A_FB, 32'hFFFF_FFFF);
        expect_reg("R8 frame offset mask", A_FB, 32'h003F_FFFF);
        bus_write(A_PITCH, 32'hFFFF_FFFF);
        expect_reg("R8 pitch mask", A_PITCH, 32'h0000_03FF);
        bus_write(A_HTIM, 32'hFFFF_FFFF);
        expect_reg("R6 htiming write while open", A_HTIM, 32'h07FF_07FF);
    endtask

    task automatic t_reclose;
        bus_write(A_GATE, 32'h0000_4759);
        expect_reg("R4 gate stores non-key", A_GATE, 32'h0000_4759);
        bus_write(A_GEN, 32'h0);
        expect_reg("R4 R5 general unchanged after closing", A_GEN, 32'hFF05_FFFF);
        expect_reg("R9 guarded read while closed", A_PITCH, 32'h0000_03FF);
    endtask

    task automatic t_key_elsewhere;
        bus_write(A_SPLIT, 32'hFFFF_4758);
        expect_reg("R7 split line writable while closed", A_SPLIT, 32'h0000_0758);
        bus_write(A_GATE + 16'h1, 32'h0000_4758);
        bus_write(A_FB, 32'h0);
        expect_reg("R11 key elsewhere does not open", A_FB, 32'h003F_FFFF);
    endtask

    task automatic t_bad_addr;
        bus_write(A_GATE, 32'h0000_4758);
        bus_write(A_GEN + 16'h2, 32'h0);
        expect_reg("R10 unaligned write ignored", A_GEN, 32'hFF05_FFFF);
        bus_write(A_GATE + 16'h2, 32'h0);
        bus_write(A_OUT, 32'h5);
        expect_reg("R10 R11 unaligned gate write keeps open", A_OUT, 32'h0000_0005);
        expect_reg("R10 read past end", BASE + 16'h20, 32'h0);
        expect_reg("R10 read below base", BASE - 16'h4, 32'h0);
        expect_reg("R10 read unaligned", A_GEN + 16'h1, 32'h0);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        bus_read(A_HTIM, v);
        check("R2 read htiming", v, 32'h07FF_07FF);
        bus_write(A_HTIM, 32'h0);
        repeat (3) @(negedge clk);
        check("R2 rdata held without read strobe", rdata, 32'h07FF_07FF);
        expect_reg("R2 new read sees updated value", A_HTIM, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_locked_start;
        t_open_back_to_back;
        t_reclose;
        t_key_elsewhere;
        t_bad_addr;
        t_hold;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule